// File: doc/BRIEF.md
# Enable-Edge Input Sample Capture

This block sits at the front of one receive channel and takes wideband input samples only when a strobe says a new one is present. Two input ports each offer a data word, an exponent and an enable line. A control word picks which port feeds the channel. It also picks whether a sample is taken on the clock edge that first follows a low-to-high change of that port's enable, or on the edge that first follows a high-to-low change.

Every capture raises a one-clock tick. The tick is meant to step the channel's oscillator phase once per real sample rather than once per clock. The captured word and exponent are held between captures, so the filter pipeline downstream can keep running on every clock. The control word also routes one of four shared sync lines to the channel. Any number of channels may choose the same sync line.

Control word `cfg[8:0]`: bits 1:0 are the capture mode, bit 6 selects the port, bits 8:7 select the sync line, and bits 5:2 are not used.

Top module: `rxcap_top`

## Requirements
- R1: With `cfg[1:0]` = 2'b10 (rising mode), a clock edge at which the selected enable is 1, when it was 0 at the previous edge, loads that port's data and exponent into `cap_data`/`cap_exp`. The new values appear right after that edge.
- R2: With `cfg[1:0]` = 2'b11 (falling mode), a clock edge at which the selected enable is 0, when it was 1 at the previous edge, loads the data and exponent in the same way.
- R3: `cap_tick` is high for exactly the one clock following each capture and low otherwise. An enable that stays at its new level gives no further ticks.
- R4: Between captures, `cap_data` and `cap_exp` keep their value whatever the data inputs do. An enable edge of the opposite direction to the mode also leaves them unchanged.
- R5: `cfg[6]` = 1 routes port B (`b_data`, `b_exp`, `b_en`) to the channel, and `cfg[6]` = 0 routes port A. Edges on the unselected port's enable cause no capture.
- R6: `sync_out` equals `sync_in[cfg[8:7]]`, combinationally. Index 0 is line A, 1 is B, 2 is C and 3 is D.
- R7: With `cfg[1:0]` = 2'b00 or 2'b01, no capture ever occurs.
- R8: While `rst_n` is low, `cap_data`, `cap_exp` and `cap_tick` are 0, and the stored enable history is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 9 | Control word: mode [1:0], port select [6], sync select [8:7] |
| a_data | input | DATA_W | Port A sample |
| a_exp | input | EXP_W | Port A exponent |
| a_en | input | 1 | Port A enable strobe |
| b_data | input | DATA_W | Port B sample |
| b_exp | input | EXP_W | Port B exponent |
| b_en | input | 1 | Port B enable strobe |
| sync_in | input | N_SYNC | Shared sync lines A..D |
| cap_data | output | DATA_W | Captured sample |
| cap_exp | output | EXP_W | Captured exponent |
| cap_tick | output | 1 | One-clock new-sample tick |
| sync_out | output | 1 | Selected sync line |

## Verification
On every clock, assertions check four things: that each qualifying enable edge in either mode is followed by a tick, that a tick never lasts two cycles, that the outputs hold still when no tick is present, and that disabled mode codes never tick. They also check that a tick carries the data of the routed port from the previous edge. Only the directed scenarios show some behaviours: which port is routed for a given bit-6 value, that the unselected port's edges are ignored, the exact sync line for each select code, and the reset values.

// File: rtl/rxcap_pkg.sv
package rxcap_pkg;
    typedef enum logic [1:0] {
        MODE_OFF0 = 2'b00,
        MODE_OFF1 = 2'b01,
        MODE_RISE = 2'b10,
        MODE_FALL = 2'b11
    } cap_mode_e;

    localparam int CFG_W       = 9;
    localparam int CFG_MODE_LO = 0;
    localparam int CFG_PORT_B  = 6;
    localparam int CFG_SYNC_LO = 7;
endpackage

// File: rtl/rxcap_port_mux.sv
module rxcap_port_mux #(
    parameter int DATA_W = 14,
    parameter int EXP_W  = 3
) (
    input  logic              use_b,
    input  logic [DATA_W-1:0] a_data,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic              a_en,
    input  logic [DATA_W-1:0] b_data,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic              b_en,
    output logic [DATA_W-1:0] sel_data,
    output logic [EXP_W-1:0]  sel_exp,
    output logic              sel_en
);
    always_comb begin
        if (use_b) begin
            sel_data = b_data;
            sel_exp  = b_exp;
            sel_en   = b_en;
        end else begin
            sel_data = a_data;
            sel_exp  = a_exp;
            sel_en   = a_en;
        end
    end
endmodule

// File: rtl/rxcap_sync_sel.sv
module rxcap_sync_sel #(
    parameter int N_SYNC = 4,
    localparam int SEL_W = (N_SYNC > 1) ? $clog2(N_SYNC) : 1
) (
    input  logic [N_SYNC-1:0] sync_in,
    input  logic [SEL_W-1:0]  sel,
    output logic              sync_out
);
    always_comb begin
        sync_out = 1'b0;
        for (int i = 0; i < N_SYNC; i++) begin
            if (sel == SEL_W'(i)) sync_out = sync_in[i];
        end
    end
endmodule

// File: rtl/rxcap_capture.sv
module rxcap_capture
    import rxcap_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int EXP_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cap_mode_e         mode,
    input  logic              en,
    input  logic [DATA_W-1:0] data_in,
    input  logic [EXP_W-1:0]  exp_in,
    output logic [DATA_W-1:0] cap_data,
    output logic [EXP_W-1:0]  cap_exp,
    output logic              cap_tick
);
    typedef struct packed {
        logic              en_prev;
        logic [DATA_W-1:0] data;
        logic [EXP_W-1:0]  expv;
        logic              tick;
    } cap_state_t;

    cap_state_t st_q, st_d;
    logic rise_seen, fall_seen, fire;

    always_comb begin
        st_d      = st_q;
        rise_seen = en & ~st_q.en_prev;
        fall_seen = ~en & st_q.en_prev;
        fire      = ((mode == MODE_RISE) && rise_seen) ||
                    ((mode == MODE_FALL) && fall_seen);
        st_d.en_prev = en;
        st_d.tick    = fire;
        if (fire) begin
            st_d.data = data_in;
            st_d.expv = exp_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_data = st_q.data;
    assign cap_exp  = st_q.expv;
    assign cap_tick = st_q.tick;

    a_r1_rise_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RISE && en && !st_q.en_prev) |=> (cap_tick && cap_data == $past(data_in)));
    a_r2_fall_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FALL && !en && st_q.en_prev) |=> (cap_tick && cap_exp == $past(exp_in)));
    a_r3_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        cap_tick |=> !cap_tick);
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_tick |-> ($stable(cap_data) && $stable(cap_exp)));
    a_r7_off_modes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF0 || mode == MODE_OFF1) |=> !cap_tick);
endmodule

// File: rtl/rxcap_top.sv
module rxcap_top
    import rxcap_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int EXP_W  = 3,
    parameter int N_SYNC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [8:0]        cfg,
    input  logic [DATA_W-1:0] a_data,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic              a_en,
    input  logic [DATA_W-1:0] b_data,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic              b_en,
    input  logic [N_SYNC-1:0] sync_in,
    output logic [DATA_W-1:0] cap_data,
    output logic [EXP_W-1:0]  cap_exp,
    output logic              cap_tick,
    output logic              sync_out
);
    localparam int SEL_W = (N_SYNC > 1) ? $clog2(N_SYNC) : 1;

    logic [DATA_W-1:0] sel_data;
    logic [EXP_W-1:0]  sel_exp;
    logic              sel_en;
    cap_mode_e         mode;
    logic              unused_cfg;

    assign mode       = cap_mode_e'(cfg[CFG_MODE_LO +: 2]);
    assign unused_cfg = ^cfg[5:2];

    rxcap_port_mux #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_mux (
        .use_b    (cfg[CFG_PORT_B]),
        .a_data   (a_data),
        .a_exp    (a_exp),
        .a_en     (a_en),
        .b_data   (b_data),
        .b_exp    (b_exp),
        .b_en     (b_en),
        .sel_data (sel_data),
        .sel_exp  (sel_exp),
        .sel_en   (sel_en)
    );

    rxcap_capture #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .en       (sel_en),
        .data_in  (sel_data),
        .exp_in   (sel_exp),
        .cap_data (cap_data),
        .cap_exp  (cap_exp),
        .cap_tick (cap_tick)
    );

    rxcap_sync_sel #(.N_SYNC(N_SYNC)) u_sync (
        .sync_in  (sync_in),
        .sel      (cfg[CFG_SYNC_LO +: SEL_W]),
        .sync_out (sync_out)
    );

    a_r5_routed_port: assert property (@(posedge clk) disable iff (!rst_n)
        cap_tick |-> (cap_data == $past(cfg[CFG_PORT_B] ? b_data : a_data)));
endmodule

// File: tb/tb_rxcap_top.sv
module tb_rxcap_top;
    localparam int DW = 14;
    localparam int EW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [8:0]    cfg = '0;
    logic [DW-1:0] a_data = '0, b_data = '0;
    logic [EW-1:0] a_exp = '0, b_exp = '0;
    logic          a_en = 1'b0, b_en = 1'b0;
    logic [3:0]    sync_in = '0;
    logic [DW-1:0] cap_data;
    logic [EW-1:0] cap_exp;
    logic          cap_tick;
    logic          sync_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rxcap_top dut (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .a_data(a_data), .a_exp(a_exp), .a_en(a_en),
        .b_data(b_data), .b_exp(b_exp), .b_en(b_en),
        .sync_in(sync_in), .cap_data(cap_data), .cap_exp(cap_exp),
        .cap_tick(cap_tick), .sync_out(sync_out)
    );

    function automatic logic [8:0] mk_cfg(input logic [1:0] m, input logic pb, input logic [1:0] s);
        return {s, pb, 4'b0000, m};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // inputs change at negedge; results of the following posedge read at the next negedge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R8 data", 32'(cap_data), 0);
        chk("R8 exp", 32'(cap_exp), 0);
        chk("R8 tick", 32'(cap_tick), 0);
    endtask

    task automatic t_rise();
        cfg = mk_cfg(2'b10, 1'b0, 2'b00);
        a_en = 0; a_data = 14'h111; a_exp = 3'd1; step();
        chk("R1 no tick while low", 32'(cap_tick), 0);
        a_en = 1; a_data = 14'h123; a_exp = 3'd5; step();
        chk("R1 data", 32'(cap_data), 32'h123);
        chk("R1 exp", 32'(cap_exp), 5);
        chk("R3 tick", 32'(cap_tick), 1);
        a_data = 14'h222; a_exp = 3'd2; step();
        chk("R3 tick drops", 32'(cap_tick), 0);
        chk("R4 data held", 32'(cap_data), 32'h123);
        chk("R4 exp held", 32'(cap_exp), 5);
        a_en = 0; a_data = 14'h333; step();
        chk("R4 fall ignored in rise mode", 32'(cap_tick), 0);
        chk("R4 data after fall", 32'(cap_data), 32'h123);
    endtask

    task automatic t_fall();
        cfg = mk_cfg(2'b11, 1'b0, 2'b00);
        a_en = 1; a_data = 14'h044; step();
        chk("R2 rise ignored", 32'(cap_tick), 0);
        chk("R2 data kept", 32'(cap_data), 32'h123);
        a_en = 0; a_data = 14'h0AB; a_exp = 3'd6; step();
        chk("R2 data", 32'(cap_data), 32'h0AB);
        chk("R2 exp", 32'(cap_exp), 6);
        chk("R3 tick on fall", 32'(cap_tick), 1);
        step();
        chk("R3 single tick", 32'(cap_tick), 0);
    endtask

    task automatic t_port();
        a_en = 0; b_en = 0;
        cfg = mk_cfg(2'b10, 1'b1, 2'b00); step();
        a_en = 1; a_data = 14'h0F0; step();
        chk("R5 port A ignored tick", 32'(cap_tick), 0);
        chk("R5 port A ignored data", 32'(cap_data), 32'h0AB);
        b_en = 1; b_data = 14'h3C5; b_exp = 3'd7; step();
        chk("R5 port B data", 32'(cap_data), 32'h3C5);
        chk("R5 port B exp", 32'(cap_exp), 7);
        chk("R5 port B tick", 32'(cap_tick), 1);
        a_en = 0; b_en = 0; step();
    endtask

    task automatic t_off();
        for (int m = 0; m < 2; m++) begin
            cfg = mk_cfg(2'(m), 1'b0, 2'b00);
            a_en = 1; a_data = 14'h155; step();
            chk("R7 no tick on rise", 32'(cap_tick), 0);
            a_en = 0; step();
            chk("R7 no tick on fall", 32'(cap_tick), 0);
            chk("R7 data kept", 32'(cap_data), 32'h3C5);
        end
    endtask

    task automatic t_sync();
        for (int s = 0; s < 4; s++) begin
            cfg = mk_cfg(2'b00, 1'b0, 2'(s));
            sync_in = 4'(1 << s); #1;
            chk("R6 selected high", 32'(sync_out), 1);
            sync_in = ~(4'(1 << s)); #1;
            chk("R6 selected low", 32'(sync_out), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_rise();
        t_fall();
        t_port();
        t_off();
        t_sync();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule